// File: doc/BRIEF.md
# Programmable Module Reset Generator

This block gives software direct control over 64 active-high reset lines that fan out to on-chip modules, plus a request for a whole-chip reset. A simple 32-bit memory-mapped port with a single-cycle valid strobe and a write flag reaches two 32-bit control words. Line n is held in the word at byte offset (n / 32) × 4, at bit n mod 32. Setting a bit drives that line high. Clearing it releases the line. The block has no auto-clear and imposes no minimum hold time: software decides how long each reset lasts.

Setting bit 31 of the word at offset 0x0 requests a chip reset instead. The block then raises a system-reset output for a fixed, parameterised number of cycles. For the length of that pulse it forces every module line high and locks the control words. When the pulse ends, every stored bit returns to zero. Reads come back registered, one cycle after the request, so software can do read-modify-write updates without touching other lines.

Top module: `rstgen_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) all 64 module lines and the system-reset output are low, and both control words read back as zero.
- R2: A write to byte offset 0x0 with bit 31 clear sets module line n (n = 0..30) to write-data bit n from the clock edge that takes the write. Line 31 follows bit 31 of this word.
- R3: A write to byte offset 0x4 sets module line n (n = 32..63) to write-data bit n-32 from the clock edge that takes the write.
- R4: A read (valid high, write low) returns the word currently stored at the addressed offset on rsp_rdata one clock after the request. rsp_rdata holds that value until the next read.
- R5: A write to one word leaves every line held in the other word unchanged.
- R6: Any address other than 0x0 and 0x4, including unaligned ones, reads as zero, and a write to it changes no module line.
- R7: A write to offset 0x0 with bit 31 set raises system_rst_o from the clock edge that takes the write. system_rst_o then stays high for exactly SYSRST_CYCLES cycles (default 16).
- R8: While system_rst_o is high, all 64 module lines are high, whatever is stored.
- R9: Writes that arrive while system_rst_o is high are ignored. When the pulse ends, both words are zero and every module line is low.
- R10: No minimum time applies between asserting and clearing a line. Writes on consecutive cycles each take effect on the next edge.
- R11: With req_valid low, no write data or address has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| module_rst_o | output | NUM_LINES (64) | Active-high module reset lines |
| system_rst_o | output | 1 | Stretched chip reset pulse |

## Verification
The bench looks for cross-talk between the two words and within a word. A decoder that ignored the upper address bits or the low two bits would alias the unmapped offsets onto real lines, and a write would then spill into the wrong word. It measures the system-reset pulse edge by edge, so a counter that is off by one shows up as a 15- or 17-cycle pulse. It also sends a write to the other word in the middle of the pulse, and then reads both words after the pulse. A design that did not lock and clear the words would leave stale bits set. Back-to-back set and clear writes catch any hidden stretching of a module line.

// File: rtl/rstgen_pkg.sv
// Shared constants for the module reset generator.
// Assumes a 32-bit data path and byte addressing with 4-byte words.
package rstgen_pkg;
    localparam int DATA_W        = 32;
    localparam int BYTES_PER_WD  = 4;
    localparam int SYSRST_BIT    = 31;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/rstgen_pulse.sv
// System-reset stretcher: a start strobe loads a down-counter, and busy_o
// stays high while it is non-zero. clear_o marks the final pulse cycle.
// Assumes start_i is only raised while busy_o is low.
module rstgen_pulse #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic clear_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on a request, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o  = (cnt_q != '0);
    assign clear_o = (cnt_q == CNT_W'(1));

    a_r7_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    a_r7_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/rstgen_regbank.sv
// Control word storage, one generated register per 32-line word. Writes are
// taken when the word's aligned offset matches and the bank is not locked.
// clear_i zeroes every word. Assumes NUM_LINES is a multiple of 32.
module rstgen_regbank
    import rstgen_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  word_t                wdata_i,
    input  logic                 lock_i,
    input  logic                 clear_i,
    output logic [NUM_LINES-1:0] bank_o
);
    localparam int NUM_WORDS = NUM_LINES / DATA_W;

    logic [NUM_WORDS-1:0] hit;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        word_t word_q;

        // Decode the aligned byte offset of this word.
        assign hit[w] = (addr_i == ADDR_W'(w * BYTES_PER_WD));

        // Hold the programmed word: clear on chip reset end, else write.
        always_ff @(posedge clk) begin
            if (!rst_n)                           word_q <= '0;
            else if (clear_i)                     word_q <= '0;
            else if (wr_en_i && hit[w] && !lock_i) word_q <= wdata_i;
        end

        assign bank_o[w*DATA_W +: DATA_W] = word_q;
    end

    a_r6_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (hit == '0) && !clear_i) |=> $stable(bank_o));
    a_r9_locked_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !clear_i) |=> $stable(bank_o));
endmodule

// File: rtl/rstgen_rdport.sv
// Registered readback: on a read strobe, captures the addressed word or zero
// for any unmapped or unaligned offset. Holds the value between reads.
module rstgen_rdport
    import rstgen_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [NUM_LINES-1:0] bank_i,
    output word_t                rdata_o
);
    localparam int NUM_WORDS = NUM_LINES / DATA_W;

    word_t sel;

    // Select the addressed word, zero when nothing matches.
    always_comb begin
        sel = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr_i == ADDR_W'(w * BYTES_PER_WD))
                sel = bank_i[w*DATA_W +: DATA_W];
        end
    end

    // Capture read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= sel;
    end

    a_r4_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/rstgen_ctrl.sv
// Top of the module reset generator. Decodes the access strobe, stores the
// per-module reset words, stretches a chip reset request into system_rst_o,
// and forces every module line high during that pulse.
// Assumes destination domains synchronise module_rst_o themselves.
module rstgen_ctrl
    import rstgen_pkg::*;
#(
    parameter int NUM_LINES     = 64,
    parameter int ADDR_W        = 8,
    parameter int SYSRST_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_LINES-1:0] module_rst_o,
    output logic                 system_rst_o
);
    logic [NUM_LINES-1:0] bank;
    logic wr_en, rd_en, sys_start, sys_busy, sys_clear;

    assign wr_en     = req_valid && req_write;
    assign rd_en     = req_valid && !req_write;
    assign sys_start = wr_en && (req_addr == '0) && req_wdata[SYSRST_BIT] && !sys_busy;

    rstgen_regbank #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(req_addr),
        .wdata_i(req_wdata), .lock_i(sys_busy), .clear_i(sys_clear), .bank_o(bank)
    );

    rstgen_pulse #(.CYCLES(SYSRST_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start_i(sys_start),
        .busy_o(sys_busy), .clear_o(sys_clear)
    );

    rstgen_rdport #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .addr_i(req_addr),
        .bank_i(bank), .rdata_o(rsp_rdata)
    );

    assign system_rst_o = sys_busy;
    assign module_rst_o = sys_busy ? '1 : bank;

    a_r2_low_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_addr == '0 && !req_wdata[SYSRST_BIT] && !system_rst_o)
        |=> module_rst_o[DATA_W-1:0] == $past(req_wdata));
    a_r9_clean_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(system_rst_o) |-> (module_rst_o == '0));
    a_r8_all_lines_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(system_rst_o) |-> (&module_rst_o));
endmodule

// File: tb/rstgen_ctrl_tb.sv
`timescale 1ns/1ps
module rstgen_ctrl_tb;
    localparam int NL = 64;
    localparam int AW = 8;
    localparam int SC = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [NL-1:0] module_rst_o;
    logic system_rst_o;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_fire = 0;

    rstgen_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .SYSRST_CYCLES(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .module_rst_o(module_rst_o), .system_rst_o(system_rst_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) rd_fire <= req_valid && !req_write;

    // Monitor: pop the expected read word and compare.
    always @(negedge clk) begin
        if (rd_fire) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s read with empty scoreboard: got %h expected none", "R4", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    errors++;
                    $display("FAIL %s read got %h expected %h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic chk(input string t, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", t, got, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got hang expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ones;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        chk("R1 lines", module_rst_o, 64'h0);
        chk("R1 sysrst", {63'h0, system_rst_o}, 64'h0);
        rd(8'h00, 32'h0, "R1");
        rd(8'h04, 32'h0, "R1");

        // R2 low word, R4 readback
        wr(8'h00, 32'h1234_5678);
        chk("R2 low lines", module_rst_o, 64'h0000_0000_1234_5678);
        rd(8'h00, 32'h1234_5678, "R4");

        // R3 high word, R5 independence
        wr(8'h04, 32'hA5A5_0F0F);
        chk("R3 high lines", module_rst_o, 64'hA5A5_0F0F_1234_5678);
        wr(8'h00, 32'h0000_0001);
        chk("R5 high word kept", module_rst_o, 64'hA5A5_0F0F_0000_0001);
        rd(8'h04, 32'hA5A5_0F0F, "R5");

        // R6 unmapped and unaligned
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        chk("R6 writes ignored", module_rst_o, 64'hA5A5_0F0F_0000_0001);
        rd(8'h08, 32'h0, "R6");
        rd(8'h05, 32'h0, "R6");

        // R11 valid low
        @(negedge clk);
        req_valid = 0; req_write = 1; req_addr = 8'h04; req_wdata = 32'h0;
        @(posedge clk); @(negedge clk);
        req_write = 0;
        chk("R11 no strobe", module_rst_o, 64'hA5A5_0F0F_0000_0001);

        // R10 back-to-back set/clear of line 40
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h04; req_wdata = 32'h0000_0100;
        @(posedge clk); @(negedge clk);
        chk("R10 set", {63'h0, module_rst_o[40]}, 64'h1);
        req_wdata = 32'h0;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R10 clear", module_rst_o, 64'h0000_0000_0000_0001);

        // R7/R8/R9 system reset pulse
        wr(8'h04, 32'h0000_00F0);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h00; req_wdata = 32'h8000_0000;
        @(posedge clk); @(negedge clk);
        chk("R7 pulse rises", {63'h0, system_rst_o}, 64'h1);
        chk("R8 all lines forced", module_rst_o, {64{1'b1}});
        // write during pulse must be ignored (R9)
        req_addr = 8'h04; req_wdata = 32'h5555_5555;
        ones = 1;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0;
        if (system_rst_o) ones++;
        for (int i = 0; i < SC + 4; i++) begin
            @(posedge clk); @(negedge clk);
            if (system_rst_o) ones++;
        end
        chk("R7 pulse width", 64'(ones), 64'(SC));
        chk("R9 lines clear after", module_rst_o, 64'h0);
        rd(8'h00, 32'h0, "R9");
        rd(8'h04, 32'h0, "R9");

        // Register works again after pulse (R3)
        wr(8'h04, 32'h8000_0000);
        chk("R3 line 63", module_rst_o, 64'h8000_0000_0000_0000);
        chk("R3 no sysrst from high word", {63'h0, system_rst_o}, 64'h0);

        repeat (3) @(negedge clk);
        chk("R4 scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule